// File: doc/BRIEF.md
# Banked Host Register Slave

This block is the byte-wide register front end that a host processor sees on a network controller's I/O window. A small address bus picks one of sixteen byte locations. The meaning of most locations depends on a bank number, which the host chooses by writing the command location at offset 0. That location is present in every bank, so the host can always switch back.

Bank 0 holds a read-only identification byte. Its low bits carry a fixed signature, and its two top bits hold a counter that steps on every read. A probe that reads the location twice can therefore tell a live chip from a floating or static bus. Bank 1 holds a ROM decode-window field and a ROM page byte, and both drive pins toward the boot ROM decoder. Bank 2 holds the pin register for a serial EEPROM. Three of its bits drive clock, select and data toward the device, and one bit reflects the device's data-out line.

Top module: `bank_regif`

## Requirements
- R1: After reset the bank is 0, the identification counter is 0, and the window field, the page byte and the three EEPROM drive bits are all 0. Offset 0 reads 0x00.
- R2: A write to offset 0 in any bank sets the bank to wdata[7:6] when that field is 0, 1 or 2, and leaves the bank unchanged when it is 3. Offset 0 reads as {bank, 6'b000000} in every bank.
- R3: In bank 0, offset 2 reads {count, 6'h24}. Masked with 0x2C it always gives 0x24.
- R4: Each clock edge with rd_en high on bank 0 offset 2 advances the 2-bit count by one, wrapping from 3 to 0, so two successive reads differ by exactly one modulo 4.
- R5: The count does not change on writes to bank 0 offset 2, on reads of any other location, or on reads of offset 2 in banks 1 and 2.
- R6: In bank 1, offset 2 stores wdata[6:4] and reads back as that field in bits 6:4, with every other bit 0. rom_win presents the field, and rom_en is 1 exactly when the field is nonzero.
- R7: In bank 1, offset 12 is an 8-bit read/write page byte presented on rom_page.
- R8: In bank 2, offset 10 holds the EEPROM pins: bit 0 clock (eep_sk), bit 1 select (eep_cs) and bit 2 data-in (eep_di) are writable. Bit 3 reads the eep_do input and ignores writes. Bits 7:4 read 0.
- R9: Every location not named above, in any bank, reads 0x00, and a write to it changes no readable state and no output.
- R10: A write to a location in one bank never alters a register of another bank at the same offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Byte offset within the I/O window |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr and current state |
| eep_do | input | 1 | Data-out line from the serial EEPROM |
| eep_sk | output | 1 | EEPROM clock |
| eep_cs | output | 1 | EEPROM select |
| eep_di | output | 1 | EEPROM data-in |
| rom_win | output | 3 | ROM decode-window field |
| rom_en | output | 1 | ROM window enabled (field nonzero) |
| rom_page | output | 8 | ROM page byte |

## Verification
The hardest condition to reach is a write landing at an offset that another bank decodes. Any such write must leave that other bank's registers alone, and the only way to see this is to switch banks and read them back. The bench walks every bank and every nonzero offset. It writes a pseudo-random byte there, then switches through all three banks and reads all sixteen offsets, comparing each byte with an arithmetic model. Every read of the identification byte in this sweep also steps the modelled counter, so the counter's wrap and its immunity to unrelated accesses are checked throughout.

// File: rtl/bank_regif.sv
module bank_regif #(
  parameter int             AW       = 4,
  parameter logic [AW-1:0]  ID_OFS   = 4'd2,
  parameter logic [AW-1:0]  WIN_OFS  = 4'd2,
  parameter logic [AW-1:0]  PAGE_OFS = 4'd12,
  parameter logic [AW-1:0]  EEP_OFS  = 4'd10,
  parameter logic [5:0]     ID_SIG   = 6'h24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          eep_do,
  output logic          eep_sk,
  output logic          eep_cs,
  output logic          eep_di,
  output logic [2:0]    rom_win,
  output logic          rom_en,
  output logic [7:0]    rom_page
);

  localparam logic [1:0] BANK_ID  = 2'd0;
  localparam logic [1:0] BANK_ROM = 2'd1;
  localparam logic [1:0] BANK_EEP = 2'd2;

  logic [1:0] bank_q;
  logic [1:0] cnt_q;
  logic [2:0] win_q;
  logic [7:0] page_q;
  logic [2:0] eep_q;

  wire sel_cmd  = (addr == '0);
  wire sel_id   = (bank_q == BANK_ID)  && (addr == ID_OFS);
  wire sel_win  = (bank_q == BANK_ROM) && (addr == WIN_OFS);
  wire sel_page = (bank_q == BANK_ROM) && (addr == PAGE_OFS);
  wire sel_eep  = (bank_q == BANK_EEP) && (addr == EEP_OFS);
  wire sel_any  = sel_cmd | sel_id | sel_win | sel_page | sel_eep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= BANK_ID;
      cnt_q  <= '0;
      win_q  <= '0;
      page_q <= '0;
      eep_q  <= '0;
    end else begin
      if (wr_en) begin
        if (sel_cmd && wdata[7:6] != 2'b11) bank_q <= wdata[7:6];
        if (sel_win)  win_q  <= wdata[6:4];
        if (sel_page) page_q <= wdata;
        if (sel_eep)  eep_q  <= wdata[2:0];
      end
      if (rd_en && sel_id) cnt_q <= cnt_q + 2'd1;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (sel_cmd)       rdata = {bank_q, 6'b0};
    else if (sel_id)   rdata = {cnt_q, ID_SIG};
    else if (sel_win)  rdata = {1'b0, win_q, 4'b0};
    else if (sel_page) rdata = page_q;
    else if (sel_eep)  rdata = {4'b0, eep_do, eep_q};
  end

  assign eep_sk   = eep_q[0];
  assign eep_cs   = eep_q[1];
  assign eep_di   = eep_q[2];
  assign rom_win  = win_q;
  assign rom_en   = |win_q;
  assign rom_page = page_q;

  assert_bank_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q != 2'b11);

  assert_bank_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0 && wdata[7:6] != 2'b11) |=> bank_q == $past(wdata[7:6]));

  assert_id_sig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_q == BANK_ID && addr == ID_OFS) |-> (rdata & 8'h2C) == 8'h24);

  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_id) |=> rdata[7:6] == $past(rdata[7:6]) + 2'd1 || !sel_id);

  assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && sel_id) |=> $stable(cnt_q));

  assert_eep_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel_eep) |=> $stable({eep_sk, eep_cs, eep_di}));

  assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_any |-> rdata == 8'h00);

  assert_rom_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_q != BANK_ROM) |=> $stable({rom_win, rom_page}));

endmodule

// File: tb/test_bank_regif.sv
`timescale 1ns/1ps
module test_bank_regif;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] addr = '0;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       eep_do = 0;
  logic       eep_sk, eep_cs, eep_di, rom_en;
  logic [2:0] rom_win;
  logic [7:0] rom_page;

  always #2.5 clk = ~clk;

  bank_regif i_bank_regif (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .eep_do(eep_do), .eep_sk(eep_sk),
    .eep_cs(eep_cs), .eep_di(eep_di), .rom_win(rom_win), .rom_en(rom_en),
    .rom_page(rom_page));

  int total = 0, bad = 0;
  bit done = 0;
  logic [1:0] m_bank = 0, m_cnt = 0;
  logic [2:0] m_win = 0, m_eep = 0;
  logic [7:0] m_page = 0;
  logic [15:0] lcg = 16'hACE1;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    if (a == 0) return {m_bank, 6'b0};
    if (m_bank == 0 && a == 2) return {m_cnt, 6'h24};
    if (m_bank == 1 && a == 2) return {1'b0, m_win, 4'b0};
    if (m_bank == 1 && a == 12) return m_page;
    if (m_bank == 2 && a == 10) return {4'b0, eep_do, m_eep};
    return 8'h00;
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    if (a == 0) return "R2";
    if (m_bank == 0 && a == 2) return "R4";
    if (m_bank == 1 && a == 2) return "R6";
    if (m_bank == 1 && a == 12) return "R7";
    if (m_bank == 2 && a == 10) return "R8";
    return "R9";
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
    if (a == 0) begin
      if (d[7:6] != 2'b11) m_bank = d[7:6];
    end else if (m_bank == 1 && a == 2) m_win = d[6:4];
    else if (m_bank == 1 && a == 12) m_page = d;
    else if (m_bank == 2 && a == 10) m_eep = d[2:0];
  endtask

  task automatic rd_chk(input logic [3:0] a);
    logic [7:0] g;
    @(negedge clk);
    addr = a; rd_en = 1;
    #1 g = rdata;
    chk(tag_of(a), g, exp_rd(a));
    if (m_bank == 0 && a == 2) begin
      chk("R3", g & 8'h2C, 8'h24);
      m_cnt = m_cnt + 2'd1;
    end
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic out_chk(input string tag);
    chk(tag, {5'b0, rom_win}, {5'b0, m_win});
    chk(tag, {7'b0, rom_en}, {7'b0, m_win != 0});
    chk(tag, rom_page, m_page);
    chk(tag, {5'b0, eep_di, eep_cs, eep_sk}, {5'b0, m_eep});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    out_chk("R1");
    rd_chk(4'd0);
    rd_chk(4'd2);
    // R4: consecutive ID reads with wrap
    for (int i = 0; i < 9; i++) rd_chk(4'd2);
    // R5: count unaffected by other accesses
    wr(4'd2, 8'hFF);
    rd_chk(4'd0);
    rd_chk(4'd5);
    wr(4'd0, 8'h40);
    rd_chk(4'd2);
    wr(4'd0, 8'h80);
    rd_chk(4'd2);
    wr(4'd0, 8'h00);
    rd_chk(4'd2);
    // R2: every command byte
    for (int d = 0; d < 256; d++) begin
      wr(4'd0, d[7:0]);
      rd_chk(4'd0);
    end
    // R6, R7: window and page sweeps
    wr(4'd0, 8'h40);
    for (int d = 0; d < 256; d++) begin
      wr(4'd2, d[7:0]);
      rd_chk(4'd2);
      out_chk("R6");
    end
    for (int d = 0; d < 256; d++) begin
      wr(4'd12, d[7:0]);
      rd_chk(4'd12);
      out_chk("R7");
    end
    // R8: EEPROM pins with both data-out levels
    wr(4'd0, 8'h80);
    for (int d = 0; d < 32; d++) begin
      eep_do = d[4];
      wr(4'd10, {4'hA, d[3:0]});
      rd_chk(4'd10);
      out_chk("R8");
    end
    // R9, R10: write everywhere, read the full map of every bank
    for (int b = 0; b < 3; b++) begin
      for (int a = 1; a < 16; a++) begin
        lcg = {lcg[14:0], lcg[15] ^ lcg[13] ^ lcg[12] ^ lcg[10]};
        eep_do = lcg[9];
        wr(4'd0, {b[1:0], 6'b0});
        wr(a[3:0], lcg[7:0]);
        out_chk("R10");
        for (int rb = 0; rb < 3; rb++) begin
          wr(4'd0, {rb[1:0], 6'b0});
          for (int ra = 0; ra < 16; ra++) rd_chk(ra[3:0]);
        end
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule